// File: doc/BRIEF.md
# Bandwidth-Adaptive Hot-Page Filter Enable

This block decides, one measurement window at a time, whether the page-cache allocation logic should filter misses so that only hot pages are allocated, or should allocate on every miss. It watches strobes from the traffic sources that use main-memory bandwidth: page fills into the DRAM page cache, page-cache write-backs, last-level-cache fills from memory and last-level-cache write-backs to memory. Each strobe carries a transfer size in 64-byte units. Several strobes may arrive in the same cycle.

The block adds up the traffic in each window. At the window's last cycle it compares the window total with the programmed peak capacity, scaled by a fixed-point threshold fraction. It does the comparison by cross-multiplication, so no divider is needed. Traffic above the threshold turns filtering on. Traffic below it turns filtering off, and every miss is then reported as hot. Traffic exactly at the threshold leaves the previous decision in place. The memory controller, the caches and the filter itself sit outside the block. They reach it only through the strobes, the filter's own hot verdict and the enable output.

Top module: `adaptive_filter_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `filter_enable` is 1 and `win_tick` is 0 unless the window length is 0 or 1. The traffic total starts at zero.
- R2: `win_tick` is high in the last cycle of each window. A window is `cfg_window` cycles long, and the count starts from the first cycle after reset. A value of 0 or 1 makes every cycle a window.
- R3: Each cycle, every lane whose `ev_valid` bit is set adds its `ev_size` field (lane i uses bits i*SZ_W and up) to the window total. Simultaneous strobes all count. A strobe in the `win_tick` cycle belongs to the window that is ending, and the total restarts from zero in the next window.
- R4: At a window end, if total*2^FRAC_W > `cfg_thresh`*`cfg_peak`, `filter_enable` is 1 from the next cycle.
- R5: At a window end, if total*2^FRAC_W < `cfg_thresh`*`cfg_peak`, `filter_enable` is 0 from the next cycle.
- R6: At a window end, if the two products are equal, `filter_enable` keeps its previous value.
- R7: `filter_enable` changes only at the clock edge that ends a `win_tick` cycle.
- R8: `alloc_hot` equals `filt_hot` while `filter_enable` is 1, and is 1 while `filter_enable` is 0. It responds in the same cycle.
- R9: The window total saturates at 2^ACC_W-1 instead of wrapping.
- R10: An `ev_size` value on a lane whose `ev_valid` bit is 0 adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | N_SRC | One traffic strobe per source lane |
| ev_size | input | N_SRC*SZ_W | Transfer size per lane in 64-byte units |
| cfg_window | input | WIN_W | Window length in cycles |
| cfg_peak | input | PEAK_W | Peak 64-byte units per window |
| cfg_thresh | input | FRAC_W | Threshold fraction, value/2^FRAC_W |
| filt_hot | input | 1 | The filter's hot verdict for the current miss |
| filter_enable | output | 1 | 1 when filtering is on |
| alloc_hot | output | 1 | Final hot verdict for the allocation logic |
| win_tick | output | 1 | High in the last cycle of each window |

## Verification
Two things can happen in one cycle: traffic is accumulated, and the window is closed. The case is provoked by strobes that arrive only in the `win_tick` cycle. The check is that the resulting decision counts that traffic, and that a later small window does not see it. The decision update and the `alloc_hot` gating also meet at each boundary. The bench judges `alloc_hot` in the first cycle of every new window against the enable value it expects for that window.

// File: rtl/afc_pkg.sv
package afc_pkg;
   typedef enum logic [1:0] {
      CMP_BELOW = 2'd0,
      CMP_EQUAL = 2'd1,
      CMP_ABOVE = 2'd2
   } cmp_e;
endpackage

// File: rtl/afc_event_sum.sv
module afc_event_sum #(
   parameter int N_SRC = 4,
   parameter int SZ_W  = 7,
   parameter int SUM_W = SZ_W + $clog2(N_SRC + 1)
) (
   input  logic [N_SRC-1:0]      ev_valid,
   input  logic [N_SRC*SZ_W-1:0] ev_size,
   output logic [SUM_W-1:0]      sum
);
   logic [SUM_W-1:0] lane [N_SRC];

   // each lane contributes its size only while its strobe is set
   for (genvar g = 0; g < N_SRC; g++) begin : g_lane
      assign lane[g] = ev_valid[g] ? SUM_W'(ev_size[g*SZ_W +: SZ_W]) : '0;
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < N_SRC; i++) sum = sum + lane[i];
   end
endmodule

// File: rtl/afc_window_timer.sv
module afc_window_timer #(
   parameter int WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIN_W-1:0] cfg_window,
   output logic             tick
);
   logic [WIN_W-1:0] cnt_q;
   logic [WIN_W-1:0] last;

   // a length of zero behaves as a length of one
   assign last = (cfg_window == '0) ? '0 : cfg_window - 1'b1;
   // >= keeps the timer from running away after a shorter length is written
   assign tick = (cnt_q >= last);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/afc_traffic_acc.sv
module afc_traffic_acc #(
   parameter int SUM_W    = 10,
   parameter int ACC_W    = 24,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SUM_W-1:0] add,
   input  logic             clear,
   output logic [ACC_W-1:0] acc_q,
   output logic [ACC_W-1:0] total
);
   logic [ACC_W:0] wide;

   assign wide = {1'b0, acc_q} + (ACC_W + 1)'(add);

   if (SATURATE) begin : g_sat
      assign total = wide[ACC_W] ? '1 : wide[ACC_W-1:0];
   end else begin : g_wrap
      assign total = wide[ACC_W-1:0];
   end

   // the total seen at a boundary already includes that cycle's traffic
   always_ff @(posedge clk) begin
      if (!rst_n)     acc_q <= '0;
      else if (clear) acc_q <= '0;
      else            acc_q <= total;
   end
endmodule

// File: rtl/afc_util_cmp.sv
module afc_util_cmp
   import afc_pkg::*;
#(
   parameter int ACC_W  = 24,
   parameter int PEAK_W = 24,
   parameter int FRAC_W = 8
) (
   input  logic [ACC_W-1:0]  total,
   input  logic [PEAK_W-1:0] peak,
   input  logic [FRAC_W-1:0] thresh,
   output cmp_e              result
);
   localparam int BASE_W = (ACC_W > PEAK_W) ? ACC_W : PEAK_W;
   localparam int PW     = BASE_W + FRAC_W + 1;

   logic [PW-1:0] lhs;
   logic [PW-1:0] rhs;

   // total/peak vs thresh/2^FRAC_W, cross-multiplied
   assign lhs = PW'(total) << FRAC_W;
   assign rhs = PW'(thresh) * PW'(peak);

   always_comb begin
      if (lhs > rhs)      result = CMP_ABOVE;
      else if (lhs < rhs) result = CMP_BELOW;
      else                result = CMP_EQUAL;
   end
endmodule

// File: rtl/adaptive_filter_ctrl.sv
module adaptive_filter_ctrl
   import afc_pkg::*;
#(
   parameter int N_SRC    = 4,
   parameter int SZ_W     = 7,
   parameter int WIN_W    = 16,
   parameter int ACC_W    = 24,
   parameter int PEAK_W   = 24,
   parameter int FRAC_W   = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_SRC-1:0]       ev_valid,
   input  logic [N_SRC*SZ_W-1:0]  ev_size,
   input  logic [WIN_W-1:0]       cfg_window,
   input  logic [PEAK_W-1:0]      cfg_peak,
   input  logic [FRAC_W-1:0]      cfg_thresh,
   input  logic                   filt_hot,
   output logic                   filter_enable,
   output logic                   alloc_hot,
   output logic                   win_tick
);
   localparam int SUM_W = SZ_W + $clog2(N_SRC + 1);

   if (N_SRC < 1 || SZ_W < 1 || WIN_W < 1 || FRAC_W < 1 || PEAK_W < 1)
      begin : g_bad_width
      $error("adaptive_filter_ctrl: all widths and counts must be positive");
   end
   if (ACC_W < SUM_W) begin : g_bad_acc
      $error("adaptive_filter_ctrl: ACC_W must hold one cycle of traffic");
   end

   logic [SUM_W-1:0] cyc_sum;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] win_total;
   cmp_e             verdict;
   logic             en_q;

   afc_event_sum #(.N_SRC(N_SRC), .SZ_W(SZ_W), .SUM_W(SUM_W)) u_sum (
      .ev_valid (ev_valid),
      .ev_size  (ev_size),
      .sum      (cyc_sum)
   );

   afc_window_timer #(.WIN_W(WIN_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_window (cfg_window),
      .tick       (win_tick)
   );

   afc_traffic_acc #(.SUM_W(SUM_W), .ACC_W(ACC_W), .SATURATE(SATURATE)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .add   (cyc_sum),
      .clear (win_tick),
      .acc_q (acc_q),
      .total (win_total)
   );

   afc_util_cmp #(.ACC_W(ACC_W), .PEAK_W(PEAK_W), .FRAC_W(FRAC_W)) u_cmp (
      .total  (win_total),
      .peak   (cfg_peak),
      .thresh (cfg_thresh),
      .result (verdict)
   );

   // filtering starts on; the decision moves only at a window end
   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b1;
      else if (win_tick) begin
         if (verdict == CMP_ABOVE)      en_q <= 1'b1;
         else if (verdict == CMP_BELOW) en_q <= 1'b0;
      end
   end

   assign filter_enable = en_q;
   assign alloc_hot     = filt_hot | ~en_q;
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
   parameter int WIN_W = 16,
   parameter int ACC_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             win_tick,
   input logic             filter_enable,
   input logic             alloc_hot,
   input logic             filt_hot,
   input logic [ACC_W-1:0] acc_q,
   input logic [WIN_W-1:0] cfg_window
);
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !win_tick |=> $stable(filter_enable));

   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      win_tick |=> (acc_q == '0));

   assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !win_tick |=> (acc_q >= $past(acc_q)));

   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (win_tick && cfg_window > 2) |=> !win_tick);

   assert_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !filter_enable |-> alloc_hot);

   assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      filter_enable |-> (alloc_hot == filt_hot));
endmodule

bind adaptive_filter_ctrl afc_checker #(.WIN_W(WIN_W), .ACC_W(ACC_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .win_tick      (win_tick),
   .filter_enable (filter_enable),
   .alloc_hot     (alloc_hot),
   .filt_hot      (filt_hot),
   .acc_q         (acc_q),
   .cfg_window    (cfg_window)
);

// File: tb/adaptive_filter_ctrl_test.sv
module adaptive_filter_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int N_SRC  = 4;
   localparam int SZ_W   = 7;
   localparam int WIN_W  = 8;
   localparam int ACC_W  = 10;
   localparam int PEAK_W = 12;
   localparam int FRAC_W = 8;
   localparam int WLEN   = 8;

   typedef struct packed {
      logic [3:0]        mask;
      logic [SZ_W-1:0]   sz;
      logic [2:0]        start;
      logic [3:0]        reps;
      logic [PEAK_W-1:0] peak;
      logic [FRAC_W-1:0] th;
      logic              exp_en;
   } vec_t;

   // one window per row; totals = popcount(mask)*sz*reps
   localparam vec_t VECS [10] = '{
      '{4'b0000,   7'd5, 3'd0, 4'd8, 12'd100,  8'd128, 1'b0}, // 0 < th: off, R10
      '{4'b0001,  7'd10, 3'd0, 4'd8, 12'd100,  8'd128, 1'b1}, // 80: above
      '{4'b1111,   7'd1, 3'd0, 4'd3, 12'd100,  8'd32,  1'b0}, // 12: just below
      '{4'b1010,  7'd25, 3'd0, 4'd1, 12'd100,  8'd128, 1'b0}, // 50: equal, hold
      '{4'b0110,  7'd28, 3'd7, 4'd1, 12'd100,  8'd128, 1'b1}, // 56 in tick cycle
      '{4'b1010,  7'd25, 3'd2, 4'd1, 12'd100,  8'd128, 1'b1}, // equal, hold
      '{4'b1000,   7'd3, 3'd0, 4'd8, 12'd200,  8'd30,  1'b1}, // 24: just above
      '{4'b0100,   7'd2, 3'd0, 4'd2, 12'd200,  8'd30,  1'b0}, // 4: below
      '{4'b1111, 7'd127, 3'd0, 4'd8, 12'd1023, 8'd255, 1'b1}, // saturates
      '{4'b0001,   7'd1, 3'd0, 4'd1, 12'd1023, 8'd1,   1'b0}  // cleared total
   };

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic [N_SRC-1:0]      ev_valid = '0;
   logic [N_SRC*SZ_W-1:0] ev_size = '0;
   logic [WIN_W-1:0]      cfg_window = WIN_W'(WLEN);
   logic [PEAK_W-1:0]     cfg_peak = '0;
   logic [FRAC_W-1:0]     cfg_thresh = '0;
   logic                  filt_hot = 1'b0;
   logic                  filter_enable;
   logic                  alloc_hot;
   logic                  win_tick;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adaptive_filter_ctrl #(
      .N_SRC(N_SRC), .SZ_W(SZ_W), .WIN_W(WIN_W), .ACC_W(ACC_W),
      .PEAK_W(PEAK_W), .FRAC_W(FRAC_W), .SATURATE(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_size(ev_size),
      .cfg_window(cfg_window), .cfg_peak(cfg_peak), .cfg_thresh(cfg_thresh),
      .filt_hot(filt_hot), .filter_enable(filter_enable),
      .alloc_hot(alloc_hot), .win_tick(win_tick)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input int wlen);
      cfg_window = WIN_W'(wlen);
      ev_valid = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drive(input logic [3:0] mask, input logic [SZ_W-1:0] sz);
      ev_valid = mask;
      for (int i = 0; i < N_SRC; i++) ev_size[i*SZ_W +: SZ_W] = sz;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic prev;
      // R1: reset state
      do_reset(WLEN);
      filt_hot = 1'b0;
      #1;
      check(filter_enable == 1'b1, "R1 enable after reset", filter_enable, 1);
      check(win_tick == 1'b0, "R1 no tick at start", win_tick, 0);
      check(alloc_hot == 1'b0, "R1/R8 gated verdict", alloc_hot, 0);

      // table walk: each row is exactly one window
      prev = 1'b1;
      for (int v = 0; v < 10; v++) begin
         cfg_peak   = VECS[v].peak;
         cfg_thresh = VECS[v].th;
         for (int c = 0; c < WLEN; c++) begin
            if (c >= int'(VECS[v].start) && c < int'(VECS[v].start) + int'(VECS[v].reps))
               drive(VECS[v].mask, VECS[v].sz);
            else
               drive(4'b0000, 7'd99); // R10: size without strobe
            #1;
            if (c == 3)
               check(filter_enable == prev, "R7 mid-window stable", filter_enable, prev);
            if (c == WLEN - 1)
               check(win_tick == 1'b1, "R2 tick at window end", win_tick, 1);
            else if (c == 0)
               check(win_tick == 1'b0, "R2 no tick at window start", win_tick, 0);
            @(posedge clk);
            @(negedge clk);
         end
         drive(4'b0000, 7'd0);
         filt_hot = 1'b0;
         #1;
         check(filter_enable == VECS[v].exp_en, "R3/R4/R5/R6/R9 decision",
               filter_enable, VECS[v].exp_en);
         check(alloc_hot == !VECS[v].exp_en, "R8 verdict gating",
               alloc_hot, !VECS[v].exp_en);
         filt_hot = 1'b1;
         #1;
         check(alloc_hot == 1'b1, "R8 hot passes", alloc_hot, 1);
         filt_hot = 1'b0;
         prev = VECS[v].exp_en;
      end

      // R2: window length 1 and 0 give a decision every cycle
      for (int w = 0; w < 2; w++) begin
         do_reset(1 - w);
         cfg_peak = 12'd100;
         cfg_thresh = 8'd128;
         #1;
         check(win_tick == 1'b1, "R2 single-cycle window tick", win_tick, 1);
         @(posedge clk); @(negedge clk);
         #1;
         check(filter_enable == 1'b0, "R5 idle one-cycle window", filter_enable, 0);
         drive(4'b0001, 7'd100);
         @(posedge clk); @(negedge clk);
         drive(4'b0000, 7'd0);
         #1;
         check(filter_enable == 1'b1, "R4 busy one-cycle window", filter_enable, 1);
         check(win_tick == 1'b1, "R2 tick every cycle", win_tick, 1);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule